// File: doc/BRIEF.md
# Odd-Subtraction Integer Square Root Engine

This block computes the integer square root of an unsigned operand. It loads the operand into a remainder register. Each clock it compares the remainder with the current odd number. If the odd number fits, the block subtracts it from the remainder, adds one to the root count and steps the odd number up by two. The sequence of odd numbers is 1, 3, 5 and so on. The first odd number that does not fit ends the run. At that point the count equals the floor of the square root.

The start interface is a level-held request. The requester drives the operand and raises `req_i`, then keeps `req_i` high until it has taken the result. The block samples the operand only on the edge at which it leaves idle. It then raises `root_valid_o` and holds the root steady for as long as `req_i` stays high. The block has no back-pressure beyond this rule: the requester releases the result by lowering `req_i`. Lowering `req_i` at any time, even partway through a run, returns the engine to idle. A new request can then start on the next edge.

Top module: `sqrt_odd_engine`

## Requirements
- R1: After reset, `root_valid_o` is 0 and `root_o` is 0.
- R2: For every 8-bit operand N, the reported root is the largest S with S*S <= N. For example, N = 27 gives S = 5.
- R3: `root_valid_o` first reads 1 after exactly S+2 rising edges. The count starts with the first edge that samples `req_i` high. It covers one load edge, S subtraction edges and one final failing compare.
- R4: N = 0 gives a root of 0, valid after two edges.
- R5: N = 255 gives a root of 15. The odd-number register reaches 31 without wrapping.
- R6: While `req_i` stays high after the result appears, `root_valid_o` stays 1 and `root_o` does not change.
- R7: One edge after `req_i` is sampled low, `root_valid_o` is 0. The next request then starts a fresh computation.
- R8: Changes on `n_i` after the load edge have no effect on the result of the run in progress.
- R9: If `req_i` drops during a run, no result is reported, and the next request still produces a correct root.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Level request; held high for the whole computation and until the result is taken |
| n_i | input | DW (8) | Unsigned operand, sampled when leaving idle |
| root_o | output | DW/2 (4) | Integer square root |
| root_valid_o | output | 1 | High while a finished root is presented |

## Verification
The bench runs every operand from 0 to 255. For each one it compares the root and the edge count to the first valid against values it computes itself. This separates an off-by-one in the compare from an off-by-one in the count or the latency. Perfect squares and values one below them (for example 15 and 16) test the boundary of the fits test. Operands 0 and 255 test the shortest run and the widest odd value. During part of the sweep the bench scrambles the operand mid-run, which shows whether the block samples the operand only once. An aborted run followed by a fresh request shows that the block returns to idle cleanly.

// File: rtl/sqrt_odd_pkg.sv
package sqrt_odd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } eng_state_e;
endpackage

// File: rtl/sqrt_odd_ctrl.sv
module sqrt_odd_ctrl
  import sqrt_odd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       fits,
  output logic       load,
  output logic       step,
  output logic       done,
  output eng_state_e state
);
  eng_state_e nxt;

  always_comb begin
    nxt = state;
    if (!req) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: nxt = ST_RUN;
        ST_RUN:  nxt = fits ? ST_RUN : ST_DONE;
        ST_DONE: nxt = ST_DONE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign load = (state == ST_IDLE) && req;
  assign step = (state == ST_RUN) && req && fits;
  assign done = (state == ST_DONE);

  // R7: a low request always empties the result stage on the next edge
  p_drop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (state == ST_IDLE));

  // R3: a result only appears straight out of a run
  p_done_from_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state) == ST_RUN));
endmodule

// File: rtl/sqrt_odd_datapath.sv
module sqrt_odd_datapath #(
  parameter int DW = 8,
  localparam int RW = DW / 2,
  localparam int OW = RW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] n_in,
  output logic          fits,
  output logic [RW-1:0] cnt,
  output logic [OW-1:0] odd
);
  logic [DW-1:0] rem;
  logic [DW-1:0] odd_ext;

  generate
    if (DW > OW) begin : g_pad
      assign odd_ext = {{(DW-OW){1'b0}}, odd};
    end else begin : g_nopad
      assign odd_ext = odd[DW-1:0];
    end
  endgenerate

  assign fits = (rem >= odd_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      odd <= OW'(1);
      cnt <= '0;
    end else if (load) begin
      rem <= n_in;
      odd <= OW'(1);
      cnt <= '0;
    end else if (step) begin
      rem <= rem - odd_ext;
      odd <= odd + OW'(2);
      cnt <= cnt + RW'(1);
    end
  end

  // R8: the remainder never grows while a run proceeds
  p_rem_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(!load)) |-> (rem <= $past(rem)));
endmodule

// File: rtl/sqrt_odd_engine.sv
module sqrt_odd_engine
  import sqrt_odd_pkg::*;
#(
  parameter int DW = 8,
  localparam int RW = DW / 2,
  localparam int OW = RW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [DW-1:0] n_i,
  output logic [RW-1:0] root_o,
  output logic          root_valid_o
);
  logic          load, step, done, fits;
  logic [RW-1:0] cnt;
  logic [OW-1:0] odd;
  eng_state_e    state;

  sqrt_odd_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_i),
    .fits  (fits),
    .load  (load),
    .step  (step),
    .done  (done),
    .state (state)
  );

  sqrt_odd_datapath #(.DW(DW)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .n_in  (n_i),
    .fits  (fits),
    .cnt   (cnt),
    .odd   (odd)
  );

  assign root_o       = cnt;
  assign root_valid_o = done;

  // R6: a presented result stays put while the request is held
  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (root_valid_o && req_i) |=> (root_valid_o && $stable(root_o)));

  // R2: a finished root leaves a remainder below the next odd number
  p_exit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    root_valid_o |-> !fits);

  // R5: odd number stays equal to twice the count plus one, no wrap
  p_odd_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (odd == {cnt, 1'b1}));
endmodule

// File: tb/sqrt_odd_engine_tb.sv
`timescale 1ns/1ps
module sqrt_odd_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0;
  logic [7:0] n_i = '0;
  logic [3:0] root_o;
  logic       root_valid_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sqrt_odd_engine #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .n_i(n_i),
    .root_o(root_o), .root_valid_o(root_valid_o)
  );

  function automatic int isqrt(input int n);
    int s = 0;
    while ((s + 1) * (s + 1) <= n) s++;
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_one(input int n, input bit scramble, input string tag);
    int s = isqrt(n);
    int edges = 0;
    @(negedge clk);
    n_i = 8'(n);
    req_i = 1'b1;
    while (edges < 40) begin
      @(posedge clk);
      edges++;
      #1;
      if (scramble && edges == 1) n_i = ~8'(n);   // R8 stimulus
      if (root_valid_o) break;
    end
    check({tag, " latency"}, edges, s + 2);
    check({tag, " root"}, int'(root_o), s);
    // R6: hold for two more edges
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1;
      check("R6 valid held", int'(root_valid_o), 1);
      check("R6 root held", int'(root_o), s);
    end
    @(negedge clk);
    req_i = 1'b0;
    @(posedge clk); #1;
    check("R7 valid cleared", int'(root_valid_o), 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid at reset", int'(root_valid_o), 0);
    check("R1 root at reset", int'(root_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 valid after reset", int'(root_valid_o), 0);

    run_one(0, 1'b0, "R4 n=0");
    run_one(27, 1'b0, "R2 n=27");
    run_one(255, 1'b0, "R5 n=255");
    for (int n = 0; n < 256; n++)
      run_one(n, (n % 3) == 1, (n % 3) == 1 ? "R8 R3 R2 sweep" : "R3 R2 sweep");

    // R9: abort a long run, then a fresh one
    @(negedge clk);
    n_i = 8'd200;
    req_i = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    @(posedge clk); #1;
    check("R9 no result after abort", int'(root_valid_o), 0);
    repeat (2) begin
      @(posedge clk); #1;
      check("R9 stays idle", int'(root_valid_o), 0);
    end
    run_one(16, 1'b0, "R9 after abort n=16");
    run_one(15, 1'b0, "R9 after abort n=15");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule